// File: doc/BRIEF.md
# Smart Card Clock Selector

This block produces the clock that drives a smart card, plus a companion clock for the host side. It has two clock sources: a crystal clock, which also clocks all of the block's logic, and a slower internal oscillator, which is sampled as data. Four control pins pick the card clock:
- a quarter of the crystal rate;
- half of the crystal rate;
- half of the internal oscillator rate;
- a pass-through of a strobe input;
- held low.

An active-low power-saving pin overrides every other pin. It stops the card clock and moves the companion clock onto the halved internal oscillator.

All pins are plain levels with no handshake. The control pins, the strobe and the oscillator are each synchronised through two flops before use.

A change of selection is glitch-free on the card side:
- The current high phase on the card clock always runs to completion.
- The card clock then stays low for a fixed gap.
- The newly chosen source then starts from a cleared divider, so its first high phase has its full length.

Top module: `card_clk_sel`

## Requirements
- R1: With active_i=1, ext_sel_i=0, rate_a_i=0, rate_b_i=0, card_clk_o is the crystal clock divided by 4 (2 cycles high, 2 low). aux_clk_o equals the crystal clock.
- R2: With active_i=1, ext_sel_i=0, rate_a_i=0, rate_b_i=1, card_clk_o is the crystal clock divided by 2. aux_clk_o equals the crystal clock.
- R3: With active_i=1, ext_sel_i=0, rate_a_i=1, rate_b_i=0, both card_clk_o and aux_clk_o carry half the internal oscillator rate. This half-rate clock toggles on each synchronised rising edge of int_osc_i.
- R4: With active_i=1, ext_sel_i=0, rate_a_i=1, rate_b_i=1, card_clk_o is held low and aux_clk_o equals the crystal clock.
- R5: With active_i=1 and ext_sel_i=1, card_clk_o follows strobe_i whatever the rate pins are, delayed by exactly 3 crystal edges. aux_clk_o equals the crystal clock.
- R6: With active_i=0 (low-power mode), card_clk_o is held low whatever the other pins and strobe_i are. aux_clk_o is half the internal oscillator rate.
- R7: A new selection is applied only while card_clk_o is low. It is followed by a forced-low gap of GAP_CYC cycles (default 4), so a high phase on card_clk_o is never cut short. Switching from stopped to divide-by-4 gives the first rising edge at the 10th crystal edge after the pins change: 2 synchroniser edges, 1 decision edge, 4 gap edges, 3 divider edges.
- R8: The divider restarts from zero when a ratio is newly selected. The first high phase of divide-by-4 after a switch therefore lasts 2 cycles.
- R9: While rst_ni is low, card_clk_o and aux_clk_o are both low. The block leaves reset in low-power selection.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_xtal_i | input | 1 | Crystal clock; clocks all logic |
| rst_ni | input | 1 | Asynchronous reset, active low |
| int_osc_i | input | 1 | Internal oscillator, sampled as data |
| active_i | input | 1 | 1 = normal operation, 0 = low-power mode |
| ext_sel_i | input | 1 | 1 = card clock follows strobe_i |
| rate_a_i | input | 1 | Rate select, upper bit |
| rate_b_i | input | 1 | Rate select, lower bit |
| strobe_i | input | 1 | External level passed to the card in strobe mode |
| card_clk_o | output | 1 | Clock to the smart card |
| aux_clk_o | output | 1 | Companion clock: crystal or halved internal oscillator |

## Verification
The bound checker watches four things on every cycle:
- the stopped and low-power selections hold the card clock low;
- the active source changes only while the card clock is low;
- the gap lasts more than one cycle;
- every divide-by-4 high phase lasts at least two cycles, and the card clock never rises in strobe mode while the synchronised strobe is low.

Only the bench scenarios can show the measured frequencies of both outputs for each pin code. They also show the exact three-edge strobe latency, the exact edge on which the first divided pulse appears after a switch, and that no runt pulse appears when a switch lands at any phase of the divider.

// File: rtl/ccs_pkg.sv
package ccs_pkg;
  localparam int DIV_CNT_W = 2;

  typedef enum logic [2:0] {
    SEL_LOWPWR  = 3'd0,
    SEL_DIV4    = 3'd1,
    SEL_DIV2    = 3'd2,
    SEL_INTHALF = 3'd3,
    SEL_STOP    = 3'd4,
    SEL_STROBE  = 3'd5
  } sel_e;

  // companion clock runs from the halved internal oscillator in these selections
  function automatic logic aux_uses_int(input sel_e s);
    return (s == SEL_INTHALF) || (s == SEL_LOWPWR);
  endfunction
endpackage

// File: rtl/ccs_sync.sv
module ccs_sync #(
  parameter int W      = 1,
  parameter int STAGES = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  localparam int CHAIN_W = W * STAGES;

  logic [CHAIN_W-1:0] chain;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) chain <= '0;
    else        chain <= {chain[CHAIN_W-W-1:0], d};
  end

  assign q = chain[CHAIN_W-1 -: W];
endmodule

// File: rtl/ccs_decode.sv
module ccs_decode
  import ccs_pkg::*;
(
  input  logic active,
  input  logic ext_sel,
  input  logic rate_a,
  input  logic rate_b,
  output sel_e req_sel
);
  always_comb begin
    if (!active)      req_sel = SEL_LOWPWR;
    else if (ext_sel) req_sel = SEL_STROBE;
    else begin
      unique case ({rate_a, rate_b})
        2'b00:   req_sel = SEL_DIV4;
        2'b01:   req_sel = SEL_DIV2;
        2'b10:   req_sel = SEL_INTHALF;
        default: req_sel = SEL_STOP;
      endcase
    end
  end
endmodule

// File: rtl/ccs_srcgen.sv
module ccs_srcgen
  import ccs_pkg::*;
(
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 int_s,
  input  logic                 cnt_clr,
  output logic [DIV_CNT_W-1:0] cnt,
  output logic                 int_half
);
  logic int_prev;
  logic int_rise;

  assign int_rise = int_s & ~int_prev;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      int_prev <= 1'b0;
      int_half <= 1'b0;
      cnt      <= '0;
    end else begin
      int_prev <= int_s;
      if (int_rise) int_half <= ~int_half;
      if (cnt_clr)  cnt <= '0;
      else          cnt <= cnt + 1'b1;
    end
  end
endmodule

// File: rtl/ccs_switch.sv
module ccs_switch
  import ccs_pkg::*;
#(
  parameter int GAP_CYC = 4
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  sel_e                 req_sel,
  input  logic [DIV_CNT_W-1:0] cnt,
  input  logic                 int_half,
  input  logic                 strb_s,
  output logic                 card_q,
  output sel_e                 cur_sel,
  output logic                 in_gap,
  output logic                 cnt_clr
);
  localparam int GW = (GAP_CYC > 1) ? $clog2(GAP_CYC) : 1;

  logic [GW-1:0] gap_cnt;
  logic          src_val;

  always_comb begin
    unique case (cur_sel)
      SEL_DIV4:    src_val = cnt[1];
      SEL_DIV2:    src_val = cnt[0];
      SEL_INTHALF: src_val = int_half;
      SEL_STROBE:  src_val = strb_s;
      default:     src_val = 1'b0;
    endcase
  end

  assign cnt_clr = in_gap;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cur_sel <= SEL_LOWPWR;
      in_gap  <= 1'b0;
      gap_cnt <= '0;
      card_q  <= 1'b0;
    end else if (in_gap) begin
      card_q <= 1'b0;
      if (gap_cnt == '0) begin
        in_gap  <= 1'b0;
        cur_sel <= req_sel;
      end else begin
        gap_cnt <= gap_cnt - 1'b1;
      end
    end else if ((req_sel != cur_sel) && !card_q) begin
      in_gap  <= 1'b1;
      gap_cnt <= GW'(GAP_CYC - 1);
      card_q  <= 1'b0;
    end else begin
      card_q <= src_val;
    end
  end
endmodule

// File: rtl/card_clk_sel.sv
module card_clk_sel
  import ccs_pkg::*;
#(
  parameter int GAP_CYC     = 4,
  parameter int SYNC_STAGES = 2
) (
  input  logic clk_xtal_i,
  input  logic rst_ni,
  input  logic int_osc_i,
  input  logic active_i,
  input  logic ext_sel_i,
  input  logic rate_a_i,
  input  logic rate_b_i,
  input  logic strobe_i,
  output logic card_clk_o,
  output logic aux_clk_o
);
  logic [3:0]           pins_s;
  logic                 strb_s;
  logic                 int_s;
  sel_e                 req_sel;
  sel_e                 cur_sel;
  logic                 in_gap;
  logic                 cnt_clr;
  logic [DIV_CNT_W-1:0] cnt;
  logic                 int_half;
  logic                 aux_int_q;

  ccs_sync #(.W(4), .STAGES(SYNC_STAGES)) u_pin_sync (
    .clk(clk_xtal_i), .rst_n(rst_ni),
    .d({active_i, ext_sel_i, rate_a_i, rate_b_i}), .q(pins_s)
  );

  ccs_sync #(.W(2), .STAGES(SYNC_STAGES)) u_sig_sync (
    .clk(clk_xtal_i), .rst_n(rst_ni),
    .d({strobe_i, int_osc_i}), .q({strb_s, int_s})
  );

  ccs_decode u_decode (
    .active(pins_s[3]), .ext_sel(pins_s[2]),
    .rate_a(pins_s[1]), .rate_b(pins_s[0]),
    .req_sel(req_sel)
  );

  ccs_srcgen u_srcgen (
    .clk(clk_xtal_i), .rst_n(rst_ni), .int_s(int_s),
    .cnt_clr(cnt_clr), .cnt(cnt), .int_half(int_half)
  );

  ccs_switch #(.GAP_CYC(GAP_CYC)) u_switch (
    .clk(clk_xtal_i), .rst_n(rst_ni), .req_sel(req_sel),
    .cnt(cnt), .int_half(int_half), .strb_s(strb_s),
    .card_q(card_clk_o), .cur_sel(cur_sel), .in_gap(in_gap),
    .cnt_clr(cnt_clr)
  );

  always_ff @(posedge clk_xtal_i or negedge rst_ni) begin
    if (!rst_ni) aux_int_q <= 1'b1;
    else         aux_int_q <= aux_uses_int(req_sel);
  end

  assign aux_clk_o = aux_int_q ? int_half : clk_xtal_i;
endmodule

// File: rtl/card_clk_sel_chk.sv
module card_clk_sel_chk
  import ccs_pkg::*;
(
  input logic clk,
  input logic rst_n,
  input logic card,
  input sel_e cur,
  input logic in_gap,
  input logic strb_s
);
  // R9
  always_comb begin
    if (!rst_n) begin
      reset_low_chk: assert (card !== 1'b1);
    end
  end

  // R4
  stop_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cur == SEL_STOP) |=> !card);

  // R6
  lowpwr_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cur == SEL_LOWPWR) |=> !card);

  // R7
  switch_while_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cur != $past(cur)) |-> !$past(card));

  // R7
  gap_min_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(in_gap) |=> in_gap);

  // R8
  div4_full_high_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ((cur == SEL_DIV4) && $rose(card)) |=> card);

  // R5
  strobe_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ((cur == SEL_STROBE) && !strb_s) |=> !card);
endmodule

bind card_clk_sel card_clk_sel_chk u_chk (
  .clk(clk_xtal_i), .rst_n(rst_ni), .card(card_clk_o),
  .cur(cur_sel), .in_gap(in_gap), .strb_s(strb_s)
);

// File: tb/sim_card_clk_sel.sv
module sim_card_clk_sel;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic int_osc = 1'b0;
  logic [3:0] pins = 4'b0000;   // {active, ext_sel, rate_a, rate_b}
  logic strobe = 1'b0;
  logic card, aux;
  int n_chk = 0;
  int n_bad = 0;

  card_clk_sel u0 (
    .clk_xtal_i(clk), .rst_ni(rst_n), .int_osc_i(int_osc),
    .active_i(pins[3]), .ext_sel_i(pins[2]), .rate_a_i(pins[1]),
    .rate_b_i(pins[0]), .strobe_i(strobe),
    .card_clk_o(card), .aux_clk_o(aux)
  );

  always #10 clk = ~clk;
  initial begin
    #7;
    forever #160 int_osc = ~int_osc;   // 16 crystal cycles per period
  end

  typedef struct packed {
    logic [3:0] pins;
    logic       strb;
    logic [7:0] hi;
    logic [7:0] rise;
    logic [7:0] apos;
    logic [7:0] aneg;
  } vec_t;

  localparam int NV = 9;
  localparam vec_t VECS [NV] = '{
    '{4'b1000, 1'b0, 8'd32, 8'd16, 8'd64, 8'd0 },  // R1 divide by 4
    '{4'b1001, 1'b0, 8'd32, 8'd32, 8'd64, 8'd0 },  // R2 divide by 2
    '{4'b1010, 1'b0, 8'd32, 8'd2,  8'd32, 8'd32},  // R3 half internal
    '{4'b1011, 1'b0, 8'd0,  8'd0,  8'd64, 8'd0 },  // R4 stopped
    '{4'b1100, 1'b1, 8'd64, 8'd0,  8'd64, 8'd0 },  // R5 strobe high
    '{4'b1111, 1'b0, 8'd0,  8'd0,  8'd64, 8'd0 },  // R5 strobe low, rate pins ignored
    '{4'b0110, 1'b0, 8'd0,  8'd0,  8'd32, 8'd32},  // R6 low power
    '{4'b0101, 1'b1, 8'd0,  8'd0,  8'd32, 8'd32},  // R6 low power, strobe ignored
    '{4'b1000, 1'b0, 8'd32, 8'd16, 8'd64, 8'd0 }   // R1 back from low power
  };

  task automatic chk(input string req, input string what, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  task automatic watch(input int n, input int chg_at, input logic [3:0] new_pins,
                       output int min_hi, output int first_rise);
    logic prev;
    int   run;
    bit   in_run;
    min_hi = 99; first_rise = -1; run = 0; in_run = 0;
    @(negedge clk); #5 prev = card;
    for (int i = 0; i < n; i++) begin
      if (i == chg_at) pins = new_pins;
      @(negedge clk); #5;
      if (!prev && card) begin
        in_run = 1; run = 1;
        if (first_rise < 0 && i >= chg_at) first_rise = i - chg_at;
      end else if (prev && card && in_run) begin
        run++;
      end else if (prev && !card && in_run) begin
        if (run < min_hi) min_hi = run;
        in_run = 0;
      end
      prev = card;
    end
  endtask

  initial begin : watchdog
    #(200000 * 20);
    n_chk++; n_bad++;
    $display("FAIL watchdog: actual 1 expected 0");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin : main
    int hi, rise, apos, aneg, min_hi, first_rise;
    logic prev;

    // R9 reset state
    repeat (3) @(posedge clk);
    #5 chk("R9", "aux high phase in reset", int'(aux), 0);
    @(negedge clk); #5;
    chk("R9", "card in reset", int'(card), 0);
    chk("R9", "aux low phase in reset", int'(aux), 0);
    rst_n = 1'b1;

    // vector table
    for (int v = 0; v < NV; v++) begin
      pins = VECS[v].pins;
      strobe = VECS[v].strb;
      repeat (60) @(negedge clk);
      #5 prev = card;
      hi = 0; rise = 0; apos = 0; aneg = 0;
      for (int k = 0; k < 64; k++) begin
        @(posedge clk); #5 apos += int'(aux);
        @(negedge clk); #5;
        hi += int'(card);
        aneg += int'(aux);
        if (!prev && card) rise++;
        prev = card;
      end
      chk($sformatf("vec%0d", v), "card high samples", hi, int'(VECS[v].hi));
      chk($sformatf("vec%0d", v), "card rising edges", rise, int'(VECS[v].rise));
      chk($sformatf("vec%0d", v), "aux high-phase samples", apos, int'(VECS[v].apos));
      chk($sformatf("vec%0d", v), "aux low-phase samples", aneg, int'(VECS[v].aneg));
    end

    // R5 strobe latency of exactly 3 edges
    pins = 4'b1100; strobe = 1'b0;
    repeat (30) @(negedge clk);
    #5 strobe = 1'b1;
    @(posedge clk); @(posedge clk); @(negedge clk); #5;
    chk("R5", "card after 2 edges (rise)", int'(card), 0);
    @(negedge clk); #5;
    chk("R5", "card after 3 edges (rise)", int'(card), 1);
    strobe = 1'b0;
    @(posedge clk); @(posedge clk); @(negedge clk); #5;
    chk("R5", "card after 2 edges (fall)", int'(card), 1);
    @(negedge clk); #5;
    chk("R5", "card after 3 edges (fall)", int'(card), 0);

    // R7 leaving divide-by-4 at every divider phase never shortens a high phase
    for (int off = 0; off < 4; off++) begin
      pins = 4'b1000;
      repeat (30) @(negedge clk);
      watch(40, 8 + off, 4'b1011, min_hi, first_rise);
      chk("R7", $sformatf("shortest high phase, offset %0d", off), min_hi, 2);
    end

    // R8 stop to divide-by-4: first rise at the 10th edge, full-length pulse
    pins = 4'b1011;
    repeat (20) @(negedge clk);
    watch(40, 4, 4'b1000, min_hi, first_rise);
    chk("R8", "first rising edge position after switch", first_rise, 9);
    chk("R8", "shortest high phase after switch", min_hi, 2);

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule